// File: doc/BRIEF.md
# Comparator Event Interrupt Controller

This block holds the one-byte control and status register of a single analog comparator channel. It also holds the logic that turns the comparator's digital output into an interrupt. Software writes the register to pick one of four analog inputs, to attach the inputs to the comparator, to enable the comparator and to choose a trigger mode. Eight modes are available: a high or low level, a rising or falling edge, any change, and debounced versions of the edge and change modes. In the debounced modes the input is sampled only on a periodic tick from an external timer.

When the chosen condition occurs, the block sets a sticky flag that stays set until software writes it back to 0. The interrupt request is the flag masked by an external interrupt-enable input. The asynchronous comparator bit first passes through a two-flop synchronizer. Disabling the comparator forces its internal output low and blocks all events. Turning the comparator on resets the edge history, so enabling it never raises a false edge.

Top module: `cmp_evt_ctrl`

## Requirements
- R1: After reset the register reads 8'hC0: select = 3 (chan_sel_o = 2'b11), connect_o = 0, flag = 0, enable = 0, mode = 000, and irq_o = 0.
- R2: The register bits are select [7:6], connect [5], flag [4], enable [3] and mode [2:0]. A write updates connect, enable and mode. The register reads back on rd_data_o in the cycle after the write. chan_sel_o follows the select field and connect_o follows the connect bit.
- R3: A write leaves the select field unchanged when the connect bit is already 1 before that write. The other fields of the same write still update.
- R4: While enable is 0, no input pattern sets the flag, not even in a level mode whose condition would hold on the real input.
- R5: Once set, the flag stays set until a write puts 0 in bit 4. Writing 1 to bit 4 never sets it. If an event occurs in the same cycle as a clearing write, the event wins.
- R6: Mode 000 (input low) and mode 111 (input high) set the flag on every clock while the condition holds, so a clearing write does not take effect while the condition persists.
- R7: Mode 001 flags a rising edge, mode 100 a falling edge and mode 101 either edge. A change on cmp_i reaches the flag on the third rising clock edge after the change.
- R8: Mode 011 flags a debounced rise, mode 110 a debounced fall and mode 010 either. A debounced change is accepted only when the synchronized input differs from the last accepted value on two consecutive tick_i pulses. One differing tick alone, or two differing ticks separated by a matching tick, sets nothing.
- R9: irq_o is 1 exactly when the flag is 1 and irq_en_i is 1.
- R10: Setting enable while the input is steady raises no edge or debounced event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmp_i | input | 1 | Asynchronous comparator output |
| tick_i | input | 1 | Debounce sampling tick from an external timer, one cycle wide |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register contents |
| irq_en_i | input | 1 | Interrupt enable from the CPU side |
| irq_o | output | 1 | Interrupt request |
| connect_o | output | 1 | Attaches the analog inputs to the comparator |
| chan_sel_o | output | 2 | Positive-input channel select (0 to 3) |

## Verification
On every cycle the assertions check the register write semantics: the select lock while connect is set, the fields that a write updates, flag stickiness and clearing while disabled, the absence of flag sets while disabled, and the interrupt masking. Only the bench scenarios can show that each of the eight modes reacts to the right input pattern with the right latency. They also show that debouncing rejects a single-tick glitch, that level modes re-assert the flag against a clearing write, and that enabling on a steady input raises nothing. The bench sweeps every mode against both starting input levels.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;
  typedef enum logic [2:0] {
    M_LOW     = 3'b000,
    M_RISE    = 3'b001,
    M_DB_TOG  = 3'b010,
    M_DB_RISE = 3'b011,
    M_FALL    = 3'b100,
    M_TOG     = 3'b101,
    M_DB_FALL = 3'b110,
    M_HIGH    = 3'b111
  } trig_mode_e;

  typedef struct packed {
    logic [1:0] sel;
    logic       con;
    logic       flag;
    logic       en;
    trig_mode_e mode;
  } ctrl_reg_t;

  localparam ctrl_reg_t CTRL_RST = '{sel: 2'b11, con: 1'b0, flag: 1'b0, en: 1'b0, mode: M_LOW};
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-2:0], d_i};
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/cmp_debounce.sv
module cmp_debounce #(
  parameter int TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic smp_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = $clog2(TICKS + 1);

  logic          acc;
  logic [CW-1:0] cnt;
  logic          diff, hit;

  always_comb begin
    diff   = smp_i != acc;
    hit    = en_i && tick_i && diff && (cnt == CW'(TICKS - 1));
    rise_o = hit && smp_i;
    fall_o = hit && !smp_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc <= 1'b0;
      cnt <= '0;
    end else if (!en_i) begin
      // reload history while off so turning on sees no change
      acc <= smp_i;
      cnt <= '0;
    end else if (tick_i) begin
      if (hit) begin
        acc <= smp_i;
        cnt <= '0;
      end else if (diff) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/cmp_evt_detect.sv
module cmp_evt_detect
  import cmp_evt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       smp_i,
  input  trig_mode_e mode_i,
  input  logic       db_rise_i,
  input  logic       db_fall_i,
  output logic       evt_o
);
  logic gated, prev, en_d, valid, rise, fall;

  always_comb begin
    gated = smp_i && en_i;
    valid = en_i && en_d;   // first enabled cycle only reloads history
    rise  = valid && gated && !prev;
    fall  = valid && !gated && prev;
    unique case (mode_i)
      M_LOW:     evt_o = en_i && !gated;
      M_HIGH:    evt_o = gated;
      M_RISE:    evt_o = rise;
      M_FALL:    evt_o = fall;
      M_TOG:     evt_o = rise || fall;
      M_DB_RISE: evt_o = db_rise_i;
      M_DB_FALL: evt_o = db_fall_i;
      M_DB_TOG:  evt_o = db_rise_i || db_fall_i;
      default:   evt_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev <= 1'b0;
      en_d <= 1'b0;
    end else begin
      prev <= gated;
      en_d <= en_i;
    end
  end
endmodule

// File: rtl/cmp_csr.sv
module cmp_csr
  import cmp_evt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       set_i,
  output ctrl_reg_t  reg_o
);
  ctrl_reg_t q, nxt, wd;

  always_comb begin
    wd  = ctrl_reg_t'(wr_data_i);
    nxt = q;
    if (wr_en_i) begin
      nxt.con  = wd.con;
      nxt.en   = wd.en;
      nxt.mode = wd.mode;
      if (!q.con)   nxt.sel  = wd.sel;
      if (!wd.flag) nxt.flag = 1'b0;
    end
    if (set_i) nxt.flag = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= CTRL_RST;
    else         q <= nxt;
  end

  assign reg_o = q;
endmodule

// File: rtl/cmp_evt_ctrl.sv
module cmp_evt_ctrl
  import cmp_evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DB_TICKS    = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmp_i,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  input  logic       irq_en_i,
  output logic       irq_o,
  output logic       connect_o,
  output logic [1:0] chan_sel_o
);
  ctrl_reg_t ctrl;
  logic      smp, db_rise, db_fall, evt;

  cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_i),
    .q_o   (smp)
  );

  cmp_debounce #(.TICKS(DB_TICKS)) u_db (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (ctrl.en),
    .tick_i(tick_i),
    .smp_i (smp),
    .rise_o(db_rise),
    .fall_o(db_fall)
  );

  cmp_evt_detect u_det (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (ctrl.en),
    .smp_i    (smp),
    .mode_i   (ctrl.mode),
    .db_rise_i(db_rise),
    .db_fall_i(db_fall),
    .evt_o    (evt)
  );

  cmp_csr u_csr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .set_i    (evt),
    .reg_o    (ctrl)
  );

  assign rd_data_o  = ctrl;
  assign irq_o      = ctrl.flag && irq_en_i;
  assign connect_o  = ctrl.con;
  assign chan_sel_o = ctrl.sel;
endmodule

// File: rtl/cmp_evt_ctrl_sva.sv
module cmp_evt_ctrl_sva (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] rd_data_o,
  input logic       irq_en_i,
  input logic       irq_o
);
  p_fields_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o[3:0] == $past(wr_data_i[3:0]) && rd_data_o[5] == $past(wr_data_i[5]));

  p_sel_locked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && rd_data_o[5]) |=> $stable(rd_data_o[7:6]));

  p_sel_open_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !rd_data_o[5]) |=> rd_data_o[7:6] == $past(wr_data_i[7:6]));

  p_no_set_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_data_o[3] && !rd_data_o[4]) |=> !rd_data_o[4]);

  p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[4] && !(wr_en_i && !wr_data_i[4])) |=> rd_data_o[4]);

  p_clear_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_data_i[4] && !rd_data_o[3]) |=> !rd_data_o[4]);

  p_irq_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_en_i && rd_data_o[4]));

  p_irq_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i && rd_data_o[4]) |-> irq_o);
endmodule

bind cmp_evt_ctrl cmp_evt_ctrl_sva u_sva (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_data_i(wr_data_i),
  .rd_data_o(rd_data_o),
  .irq_en_i (irq_en_i),
  .irq_o    (irq_o)
);

// File: tb/cmp_evt_ctrl_tb_top.sv
module cmp_evt_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp = 1'b0, tick = 1'b0, wr_en = 1'b0, irq_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq, con;
  logic [1:0] sel;
  int         total = 0, bad = 0;

  always #4 clk = ~clk;

  cmp_evt_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmp_i(cmp), .tick_i(tick),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .irq_en_i(irq_en), .irq_o(irq), .connect_o(con), .chan_sel_o(sel)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic run_mode(input int m, input logic a);
    logic lvl_old, lvl_new, is_db, exp_e, exp_d;
    lvl_old = (m == 0 && !a) || (m == 7 && a);
    lvl_new = (m == 0 && a) || (m == 7 && !a);
    is_db   = (m == 2 || m == 3 || m == 6);
    cmp = a;
    wr(8'(m)); wr(8'(m));
    cyc(5);
    chk($sformatf("R4 m=%0d a=%0d disabled", m, a), 8'(rd_data[4]), 8'h00);
    wr(8'h08 | 8'(m));
    cyc(5);
    chk($sformatf("R10/R6 m=%0d a=%0d enable", m, a), 8'(rd_data[4]), 8'(lvl_old));
    wr(8'h08 | 8'(m));
    cyc(2);
    chk($sformatf("R6 m=%0d a=%0d clear vs level", m, a), 8'(rd_data[4]), 8'(lvl_old));
    cmp = ~a;
    cyc(4);
    exp_e = (m == 0) || (m == 7) || (m == 5) || (m == 1 && !a) || (m == 4 && a);
    chk($sformatf("R7 m=%0d a=%0d edge", m, a), 8'(rd_data[4]), 8'(exp_e));
    pulse_tick(); cyc(3);
    chk($sformatf("R8 m=%0d a=%0d one tick", m, a), 8'(rd_data[4]), 8'(exp_e));
    pulse_tick(); cyc(3);
    exp_d = exp_e || (m == 2) || (m == 3 && !a) || (m == 6 && a);
    chk($sformatf("R8 m=%0d a=%0d two ticks", m, a), 8'(rd_data[4]), 8'(exp_d));
    irq_en = 1'b1; cyc(1);
    chk($sformatf("R9 m=%0d a=%0d irq on", m, a), 8'(irq), 8'(exp_d));
    irq_en = 1'b0; cyc(1);
    chk($sformatf("R9 m=%0d a=%0d irq masked", m, a), 8'(irq), 8'h00);
    wr(8'h08 | 8'(m));
    cyc(2);
    chk($sformatf("R5 m=%0d a=%0d clear", m, a), 8'(rd_data[4]), 8'(lvl_new));
    wr(8'h18 | 8'(m));
    cyc(1);
    chk($sformatf("R5 m=%0d a=%0d write one", m, a), 8'(rd_data[4]), 8'(lvl_new));
    if (is_db) begin
      cmp = a; cyc(4);
      pulse_tick();
      cmp = ~a; cyc(4);
      pulse_tick(); pulse_tick(); cyc(3);
      chk($sformatf("R8 m=%0d a=%0d glitch", m, a), 8'(rd_data[4]), 8'h00);
    end
  endtask

  initial begin
    cyc(3);
    chk("R1 reset reg", rd_data, 8'hC0);
    chk("R1 reset sel", 8'(sel), 8'h03);
    chk("R1 reset con", 8'(con), 8'h00);
    chk("R1 reset irq", 8'(irq), 8'h00);
    rst_n = 1'b1;
    cyc(2);
    wr(8'h66);
    chk("R2 readback", rd_data, 8'h66);
    chk("R2 chan_sel_o", 8'(sel), 8'h01);
    chk("R2 connect_o", 8'(con), 8'h01);
    wr(8'hA3);
    chk("R3 locked sel", rd_data, 8'h63);
    wr(8'h83);
    chk("R3 locked until con low", rd_data, 8'h43);
    wr(8'h83);
    chk("R3 open sel", rd_data, 8'h83);
    chk("R3 chan_sel_o", 8'(sel), 8'h02);
    for (int m = 0; m < 8; m++)
      for (int a = 0; a < 2; a++)
        run_mode(m, a[0]);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule